// File: doc/BRIEF.md
# Floating-Point Status Register Unit

This unit keeps the accrued floating-point exception flags and the dynamic rounding mode of a processor core, and presents them to the CSR access path as three views: flags only, rounding mode only, and a combined word that packs both. The CSR pipeline sends an address with read and write strobes. In the same cycle the unit returns read data, an illegal-access indication, and a request that the core mark its floating-point context state dirty.

Access is gated by the two-bit floating-point context state from the core's status register. When that state is off, an ordinary access to any of the three views is refused and leaves the stored state alone. A debug access bypasses the gate. Alongside the CSR path, the FPU reports newly raised exceptions as a flag vector that is ORed into the stored flags. Addresses outside the three views belong to other units and are ignored.

Top module: `fpcsr_unit`

## Requirements
- R1: After reset the stored flags and rounding mode are zero, so a legal read of the combined view returns 0.
- R2: With context state 2'b00 and the debug flag low, a read or write of any of the three views raises `csr_illegal` in the same cycle, returns read data 0, raises no dirty request and changes no stored state.
- R3: With the debug flag high, an access is legal whatever the context state; with a nonzero context state every access to the three views is legal.
- R4: `fs_dirty_req` is high in exactly the cycle of a legal write to any of the three views; reads, refused accesses and accesses to other addresses leave it low.
- R5: A legal write to the flags view (address 0x001) stores write data bits [4:0] as the flags and ignores the rest; a read of that view returns the flags in bits [4:0] with all other bits zero.
- R6: A legal write to the rounding-mode view (address 0x002) stores write data bits [2:0] as the rounding mode and ignores the rest; a read returns it in bits [2:0] with all other bits zero.
- R7: A read of the combined view (address 0x003) returns the flags in bits [4:0], the rounding mode in bits [7:5] and zero in every bit above.
- R8: A legal write to the combined view loads the flags from bits [4:0] and the rounding mode from bits [7:5] in the same cycle.
- R9: In any cycle without a legal write that loads the flags, `acc_valid` ORs `acc_flags` into the stored flags; a write to the rounding-mode view alone does not block this.
- R10: When a legal write to the flags or combined view coincides with `acc_valid`, the written value alone is stored.
- R11: An access to any other address raises neither `csr_illegal` nor `fs_dirty_req`, returns 0 and changes no stored state.
- R12: During a simultaneous read and write the read data shows the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | 12 | CSR address of the current access |
| csr_rd | input | 1 | Read strobe |
| csr_wr | input | 1 | Write strobe |
| csr_wdata | input | 32 | Write data |
| fs_state | input | 2 | Floating-point context state from the core status register, 0 = off |
| dbg_access | input | 1 | Access comes from the debugger and bypasses the context gate |
| acc_valid | input | 1 | FPU reports exceptions this cycle |
| acc_flags | input | 5 | Exception bits to accumulate |
| csr_rdata | output | 32 | Read data, zero unless a legal read hits a view |
| csr_illegal | output | 1 | Access refused because the context state is off |
| fs_dirty_req | output | 1 | Request to set the context state to dirty (2'b11) |

## Verification
The bench sweeps every combination of view, context state, debug flag and read or write. It checks the same-cycle outputs and then reads the stored state back through the debug path, so a gate that leaks a refused write or skips the debug bypass shows up as a wrong read-back. The masking corners use write data with every high bit set: a unit that keeps too many bits, or swaps the packing of the combined word, returns nonzero upper bits or a shifted rounding mode. Accumulation is driven against flag writes, rounding-mode writes and idle cycles. A wrong priority either leaves accumulated bits behind after a flag write or drops them during a rounding-mode write. Foreign addresses are hit with writes while the context is off, which catches a decoder that flags or dirties accesses it does not own.

// File: rtl/fpcsr_pkg.sv
package fpcsr_pkg;

   // index of each view inside the one-hot view vector
   localparam int unsigned VIEW_FLG = 0;
   localparam int unsigned VIEW_RND = 1;
   localparam int unsigned VIEW_ALL = 2;
   localparam int unsigned N_VIEWS  = 3;

   // context-state encodings
   localparam logic [1:0] CTX_OFF   = 2'b00;
   localparam logic [1:0] CTX_DIRTY = 2'b11;

   typedef struct packed {
      logic all;
      logic rnd;
      logic flg;
   } view_t;

endpackage

// File: rtl/fpcsr_decode.sv
module fpcsr_decode
   import fpcsr_pkg::*;
#(
   parameter int unsigned     ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] ADDR_FLG = 12'h001,
   parameter logic [ADDR_W-1:0] ADDR_RND = 12'h002,
   parameter logic [ADDR_W-1:0] ADDR_ALL = 12'h003
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic [1:0]        ctx,
   input  logic              dbg,
   output view_t             view,
   output logic              rd_ok,
   output logic              wr_ok,
   output logic              refused
);

   localparam logic [N_VIEWS*ADDR_W-1:0] VIEW_ADDRS = {ADDR_ALL, ADDR_RND, ADDR_FLG};

   if ((ADDR_FLG == ADDR_RND) || (ADDR_FLG == ADDR_ALL) || (ADDR_RND == ADDR_ALL)) begin : g_bad_addr
      $error("fpcsr_decode: view addresses must be distinct");
   end

   logic [N_VIEWS-1:0] hit_vec;

   for (genvar v = 0; v < N_VIEWS; v++) begin : g_hit
      assign hit_vec[v] = (addr == VIEW_ADDRS[v*ADDR_W +: ADDR_W]);
   end

   logic any_hit;
   logic gate_open;
   logic touch;

   always_comb begin
      view     = '{all: hit_vec[VIEW_ALL], rnd: hit_vec[VIEW_RND], flg: hit_vec[VIEW_FLG]};
      any_hit  = |hit_vec;
      gate_open = dbg || (ctx != CTX_OFF);
      touch    = any_hit && (rd || wr);
      rd_ok    = any_hit && rd && gate_open;
      wr_ok    = any_hit && wr && gate_open;
      refused  = touch && !gate_open;
   end

   // decoded view is one-hot or empty
   p_view_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(view));

   // refusal only for an ordinary access while the context is off
   p_refuse_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      refused |-> ((ctx == CTX_OFF) && !dbg && (rd || wr)));

   // debug never refused
   p_dbg_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dbg |-> !refused);

   // a write is never both accepted and refused
   p_wr_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_ok && refused));

endmodule

// File: rtl/fpcsr_flags.sv
module fpcsr_flags #(
   parameter int unsigned FLAG_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [FLAG_W-1:0] load_val,
   input  logic              acc_valid,
   input  logic [FLAG_W-1:0] acc_flags,
   output logic [FLAG_W-1:0] flags
);

   if (FLAG_W < 1) begin : g_bad_w
      $error("fpcsr_flags: FLAG_W must be at least 1");
   end

   logic [FLAG_W-1:0] flags_d;

   always_comb begin
      for (int b = 0; b < FLAG_W; b++) begin
         if (load) begin
            flags_d[b] = load_val[b];
         end else begin
            flags_d[b] = flags[b] | (acc_valid & acc_flags[b]);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
      end else begin
         flags <= flags_d;
      end
   end

   // accumulated bits end up set when nothing loads the flags
   p_acc_or_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !load) |=> ((flags & $past(acc_flags)) == $past(acc_flags)));

   // accumulation never clears a bit
   p_acc_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> ((flags & $past(flags)) == $past(flags)));

   // a load overrides any accumulation in the same cycle
   p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (flags == $past(load_val)));

   // idle cycles hold the flags
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !acc_valid) |=> $stable(flags));

endmodule

// File: rtl/fpcsr_round.sv
module fpcsr_round #(
   parameter int unsigned RM_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [RM_W-1:0] load_val,
   output logic [RM_W-1:0] rmode
);

   if (RM_W < 1) begin : g_bad_w
      $error("fpcsr_round: RM_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rmode <= '0;
      end else if (load) begin
         rmode <= load_val;
      end
   end

   p_rm_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(rmode));

   p_rm_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (rmode == $past(load_val)));

endmodule

// File: rtl/fpcsr_rdmux.sv
module fpcsr_rdmux
   import fpcsr_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned FLAG_W = 5,
   parameter int unsigned RM_W   = 3
) (
   input  logic              rd_ok,
   input  view_t             view,
   input  logic [FLAG_W-1:0] flags,
   input  logic [RM_W-1:0]   rmode,
   output logic [DATA_W-1:0] rdata
);

   localparam int unsigned PACK_W = FLAG_W + RM_W;

   if (PACK_W > DATA_W) begin : g_bad_w
      $error("fpcsr_rdmux: packed word wider than data path");
   end

   always_comb begin
      rdata = '0;
      if (rd_ok) begin
         unique case (1'b1)
            view.flg: rdata[FLAG_W-1:0] = flags;
            view.rnd: rdata[RM_W-1:0]   = rmode;
            view.all: rdata[PACK_W-1:0] = {rmode, flags};
            default:  rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/fpcsr_unit.sv
module fpcsr_unit
   import fpcsr_pkg::*;
#(
   parameter int unsigned       ADDR_W   = 12,
   parameter int unsigned       DATA_W   = 32,
   parameter int unsigned       FLAG_W   = 5,
   parameter int unsigned       RM_W     = 3,
   parameter logic [ADDR_W-1:0] ADDR_FLG = 12'h001,
   parameter logic [ADDR_W-1:0] ADDR_RND = 12'h002,
   parameter logic [ADDR_W-1:0] ADDR_ALL = 12'h003
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic              csr_rd,
   input  logic              csr_wr,
   input  logic [DATA_W-1:0] csr_wdata,
   input  logic [1:0]        fs_state,
   input  logic              dbg_access,
   input  logic              acc_valid,
   input  logic [FLAG_W-1:0] acc_flags,
   output logic [DATA_W-1:0] csr_rdata,
   output logic              csr_illegal,
   output logic              fs_dirty_req
);

   localparam int unsigned PACK_W = FLAG_W + RM_W;

   if (PACK_W >= DATA_W) begin : g_bad_pack
      $error("fpcsr_unit: DATA_W must exceed FLAG_W + RM_W");
   end

   view_t view;
   logic  rd_ok;
   logic  wr_ok;
   logic  refused;

   fpcsr_decode #(
      .ADDR_W  (ADDR_W),
      .ADDR_FLG(ADDR_FLG),
      .ADDR_RND(ADDR_RND),
      .ADDR_ALL(ADDR_ALL)
   ) u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .addr   (csr_addr),
      .rd     (csr_rd),
      .wr     (csr_wr),
      .ctx    (fs_state),
      .dbg    (dbg_access),
      .view   (view),
      .rd_ok  (rd_ok),
      .wr_ok  (wr_ok),
      .refused(refused)
   );

   // write steering: the combined view loads both fields from the packed word
   logic              flg_load;
   logic [FLAG_W-1:0] flg_val;
   logic              rm_load;
   logic [RM_W-1:0]   rm_val;

   always_comb begin
      flg_load = wr_ok && (view.flg || view.all);
      flg_val  = csr_wdata[FLAG_W-1:0];
      rm_load  = wr_ok && (view.rnd || view.all);
      rm_val   = view.all ? csr_wdata[PACK_W-1:FLAG_W] : csr_wdata[RM_W-1:0];
   end

   logic unused_wdata_hi;
   assign unused_wdata_hi = ^csr_wdata[DATA_W-1:PACK_W];

   logic [FLAG_W-1:0] flags;
   logic [RM_W-1:0]   rmode;

   fpcsr_flags #(.FLAG_W(FLAG_W)) u_flg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (flg_load),
      .load_val (flg_val),
      .acc_valid(acc_valid),
      .acc_flags(acc_flags),
      .flags    (flags)
   );

   fpcsr_round #(.RM_W(RM_W)) u_rnd (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (rm_load),
      .load_val(rm_val),
      .rmode   (rmode)
   );

   fpcsr_rdmux #(
      .DATA_W(DATA_W),
      .FLAG_W(FLAG_W),
      .RM_W  (RM_W)
   ) u_rmux (
      .rd_ok(rd_ok),
      .view (view),
      .flags(flags),
      .rmode(rmode),
      .rdata(csr_rdata)
   );

   assign csr_illegal  = refused;
   assign fs_dirty_req = wr_ok;

   // bits above the packed word never carry data
   p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      csr_rdata[DATA_W-1:PACK_W] == '0);

   // a refused access returns nothing and requests nothing
   p_refused_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      csr_illegal |-> (csr_rdata == '0) && !fs_dirty_req);

   // dirty request only with a write strobe and an open gate
   p_dirty_needs_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fs_dirty_req |-> (csr_wr && ((fs_state != CTX_OFF) || dbg_access)));

   // refused access leaves the rounding mode untouched
   p_refused_hold_rm_r2: assert property (@(posedge clk) disable iff (!rst_n)
      csr_illegal |=> $stable(rmode));

endmodule

// File: tb/sim_fpcsr_unit.sv
module sim_fpcsr_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] csr_addr = '0;
   logic        csr_rd = 1'b0;
   logic        csr_wr = 1'b0;
   logic [31:0] csr_wdata = '0;
   logic [1:0]  fs_state = '0;
   logic        dbg_access = 1'b0;
   logic        acc_valid = 1'b0;
   logic [4:0]  acc_flags = '0;
   logic [31:0] csr_rdata;
   logic        csr_illegal;
   logic        fs_dirty_req;

   always #5 clk = ~clk;

   fpcsr_unit u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .csr_addr    (csr_addr),
      .csr_rd      (csr_rd),
      .csr_wr      (csr_wr),
      .csr_wdata   (csr_wdata),
      .fs_state    (fs_state),
      .dbg_access  (dbg_access),
      .acc_valid   (acc_valid),
      .acc_flags   (acc_flags),
      .csr_rdata   (csr_rdata),
      .csr_illegal (csr_illegal),
      .fs_dirty_req(fs_dirty_req)
   );

   int unsigned n_chk = 0;
   int unsigned n_err = 0;
   bit          done  = 1'b0;
   logic [4:0]  m_flg = '0;
   logic [2:0]  m_rm  = '0;

   localparam logic [11:0] A_FLG = 12'h001;
   localparam logic [11:0] A_RND = 12'h002;
   localparam logic [11:0] A_ALL = 12'h003;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      case (a)
         A_FLG:   return {27'd0, m_flg};
         A_RND:   return {29'd0, m_rm};
         A_ALL:   return {24'd0, m_rm, m_flg};
         default: return 32'd0;
      endcase
   endfunction

   // one access cycle: drive at negedge, check same-cycle outputs, update model at posedge
   task automatic access(input logic [11:0] a, input bit rd, input bit wr,
                         input logic [31:0] wd, input logic [1:0] fs, input bit dbg,
                         input bit av, input logic [4:0] af, input string tag);
      bit hit, open, legal, loads_flg;
      logic [31:0] er;
      @(negedge clk);
      csr_addr = a; csr_rd = rd; csr_wr = wr; csr_wdata = wd;
      fs_state = fs; dbg_access = dbg; acc_valid = av; acc_flags = af;
      #2;
      hit   = (a == A_FLG) || (a == A_RND) || (a == A_ALL);
      open  = dbg || (fs != 2'b00);
      legal = hit && open;
      er    = (rd && legal) ? exp_read(a) : 32'd0;
      chk({tag, " illegal"}, {31'd0, csr_illegal}, {31'd0, hit && (rd || wr) && !open});
      chk({tag, " dirty"},   {31'd0, fs_dirty_req}, {31'd0, wr && legal});
      chk({tag, " rdata"},   csr_rdata, er);
      @(posedge clk);
      loads_flg = wr && legal && (a == A_FLG || a == A_ALL);
      if (wr && legal) begin
         if (a == A_FLG) m_flg = wd[4:0];
         if (a == A_RND) m_rm  = wd[2:0];
         if (a == A_ALL) begin m_flg = wd[4:0]; m_rm = wd[7:5]; end
      end
      if (!loads_flg && av) m_flg = m_flg | af;
      #1;
      csr_rd = 1'b0; csr_wr = 1'b0; acc_valid = 1'b0; dbg_access = 1'b0;
   endtask

   // debug read-back of the combined view
   task automatic peek(input string tag);
      access(A_ALL, 1'b1, 1'b0, 32'd0, 2'b00, 1'b1, 1'b0, 5'd0, tag);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      csr_addr = A_ALL; csr_rd = 1'b1; dbg_access = 1'b1; #2;
      chk("R1 reset combined", csr_rdata, 32'd0);
      csr_rd = 1'b0; dbg_access = 1'b0;

      // R2 R3 R4 R5 R6 R7: sweep view x context x debug x op
      for (int fs = 0; fs < 4; fs++) begin
         for (int d = 0; d < 2; d++) begin
            for (int v = 0; v < 3; v++) begin
               for (int op = 0; op < 3; op++) begin
                  logic [11:0] a;
                  logic [31:0] wd;
                  string tg;
                  a  = 12'(v + 1);
                  wd = 32'hFFFF_FF00 | 32'((fs * 53 + v * 29 + d * 11 + op * 7) & 8'hFF);
                  tg = (fs == 0 && d == 0) ? "R2" : "R3";
                  if (v == 0) tg = {tg, "/R5"};
                  if (v == 1) tg = {tg, "/R6"};
                  if (v == 2) tg = {tg, "/R7"};
                  access(a, op != 1, op != 0, wd, 2'(fs), d[0], 1'b0, 5'd0, {tg, "/R4 sweep"});
                  peek("R2 state readback");
               end
            end
         end
      end

      // R8: combined write loads both fields together
      access(A_ALL, 1'b0, 1'b1, 32'hFFFF_FF6A, 2'b01, 1'b0, 1'b0, 5'd0, "R8 combined write");
      peek("R8 readback");
      access(A_FLG, 1'b1, 1'b0, 32'd0, 2'b10, 1'b0, 1'b0, 5'd0, "R8 flags after combined");
      access(A_RND, 1'b1, 1'b0, 32'd0, 2'b10, 1'b0, 1'b0, 5'd0, "R8 rm after combined");

      // R9: accumulation from a cleared state, all patterns
      access(A_FLG, 1'b0, 1'b1, 32'd0, 2'b11, 1'b0, 1'b0, 5'd0, "R9 clear");
      for (int p = 0; p < 32; p++) begin
         access(12'h7C0, 1'b0, 1'b0, 32'd0, 2'b11, 1'b0, 1'b1, 5'(p), "R9 accumulate");
         peek("R9 readback");
         if (p % 8 == 7)
            access(A_FLG, 1'b0, 1'b1, 32'd0, 2'b11, 1'b0, 1'b0, 5'd0, "R9 reclear");
      end
      // R9: rounding-mode-only write does not block accumulation
      access(A_RND, 1'b0, 1'b1, 32'h0000_0005, 2'b01, 1'b0, 1'b1, 5'h12, "R9 rm write with acc");
      peek("R9 rm write readback");
      // R9: refused write does not block accumulation
      access(A_FLG, 1'b0, 1'b1, 32'd0, 2'b00, 1'b0, 1'b1, 5'h04, "R9 refused write with acc");
      peek("R9 refused readback");

      // R10: flag write wins over accumulation
      access(A_FLG, 1'b0, 1'b1, 32'h0000_0000, 2'b01, 1'b0, 1'b1, 5'h1F, "R10 flags view vs acc");
      peek("R10 readback a");
      access(A_ALL, 1'b0, 1'b1, 32'h0000_0041, 2'b10, 1'b0, 1'b1, 5'h1E, "R10 combined vs acc");
      peek("R10 readback b");
      access(A_ALL, 1'b0, 1'b1, 32'h0000_00E2, 2'b00, 1'b1, 1'b1, 5'h0D, "R10 debug combined vs acc");
      peek("R10 readback c");

      // R11: foreign addresses
      for (int k = 0; k < 6; k++) begin
         logic [11:0] fa;
         fa = (k < 3) ? 12'(k * 4) : 12'(12'h300 + k);
         access(fa, 1'b1, 1'b1, 32'hFFFF_FFFF, 2'(k % 4), 1'b0, 1'b0, 5'd0, "R11 foreign");
         peek("R11 readback");
      end

      // R12: read while writing returns the old value
      access(A_ALL, 1'b1, 1'b1, 32'h0000_0033, 2'b11, 1'b0, 1'b0, 5'd0, "R12 rw combined");
      access(A_FLG, 1'b1, 1'b1, 32'h0000_0015, 2'b01, 1'b0, 1'b0, 5'd0, "R12 rw flags");
      access(A_RND, 1'b1, 1'b1, 32'h0000_0006, 2'b00, 1'b1, 1'b0, 5'd0, "R12 rw rm");
      peek("R12 readback");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule